// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indication

This block compares two single-cycle strobes in one system clock domain. One strobe marks each edge of the divided reference, and the other marks each edge of the divided feedback (VCO) clock. From these it forms the error signals for a synthesizer loop. The core is a two-flop tri-state detector. A reference edge arms a "pump up" flop and a feedback edge arms a "pump down" flop. When both flops are armed, both are cleared on the next clock.

The same detector state drives two error views, and both are registered.
- The first is a single-ended output modelled as a drive level plus an output enable. It drives high while only the reference side is ahead. It drives low while only the feedback side is ahead. It floats otherwise.
- The second is a pair of active-low pulse lines, one for each input.

A lock flag rises after a programmable number of reference edges pass without any error pulse longer than one clock. Any longer pulse drops the flag.

Top module: `pfd_lock_detector`

## Requirements
- R1: After synchronous reset, se_oe=0, se_drive=0, phi_r_n=1, phi_v_n=1 and lock=0.
- R2: From idle, a reference strobe alone gives, from the next cycle, se_oe=1, se_drive=1, phi_r_n=0 and phi_v_n=1.
- R3: From idle, a feedback strobe alone gives, from the next cycle, se_oe=1, se_drive=0, phi_v_n=0 and phi_r_n=1.
- R4: When the lagging strobe arrives, both pulse lines are low and se_oe=0 for exactly one cycle. If no strobe arrives in that cycle, both lines return to 1 in the following cycle.
- R5: Strobes on both inputs in the same cycle leave the detector state unchanged. From idle, no error pulse appears. From a pending state, that state is held.
- R6: se_oe is 1 exactly when one of phi_r_n and phi_v_n is low.
- R7: While se_oe=1, se_drive equals 1 when phi_r_n is low and 0 when phi_v_n is low.
- R8: lock becomes 1 at the clock edge that counts the LOCK_CYCLES-th (default 4) reference strobe since reset or since the last long error. It reads 0 after fewer strobes.
- R9: If se_oe is 1 for two consecutive cycles, lock is 0 from the cycle after the second such cycle.
- R10: A strobe arriving during the one-cycle clearing state is not lost. A reference strobe there leaves the detector in the pump-up state.
- R11: Error pulses of exactly one cycle do not clear lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fr_tick | input | 1 | One-cycle strobe per divided reference edge |
| fv_tick | input | 1 | One-cycle strobe per divided feedback edge |
| se_drive | output | 1 | Level of the single-ended error output when enabled |
| se_oe | output | 1 | Enable of the single-ended output (0 means high impedance) |
| phi_r_n | output | 1 | Active-low pulse, reference side ahead |
| phi_v_n | output | 1 | Active-low pulse, feedback side ahead |
| lock | output | 1 | Lock indication |

## Verification
Assertions check several properties on every cycle:
- The single-ended enable agrees with the pulse pair.
- The drive polarity agrees with whichever line is active.
- An armed detector with both flops set clears when no strobe arrives.
- Coincident strobes never start a pulse.
- A two-cycle error always drops lock.

Other behaviour depends on particular strobe histories, and only the directed scenarios can show it:
- the exact cycle at which lock rises after the counted reference edges;
- survival of lock across one-cycle pulses;
- capture of a strobe that lands in the clearing cycle.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
package pfd_pkg;
  // Encoding of the detector flops as {down, up}
  typedef enum logic [1:0] {
    ERR_IDLE    = 2'b00,
    ERR_PUMP_UP = 2'b01,
    ERR_PUMP_DN = 2'b10,
    ERR_BOTH    = 2'b11
  } err_state_e;
endpackage

// File: rtl/pfd_state_core.sv
`timescale 1ns/1ps
module pfd_state_core (
  input  logic clk,
  input  logic rst,
  input  logic fr_tick,
  input  logic fv_tick,
  output logic up_nx,
  output logic dn_nx
);
  logic up_q, dn_q;
  logic clr, set_up, set_dn;

  always_comb begin
    clr    = up_q & dn_q;
    set_up = fr_tick & ~fv_tick;
    set_dn = fv_tick & ~fr_tick;
    up_nx  = (up_q & ~clr) | set_up;
    dn_nx  = (dn_q & ~clr) | set_dn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_nx;
      dn_q <= dn_nx;
    end
  end

  // R2
  up_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!up_q && !dn_q && fr_tick && !fv_tick) |=> (up_q && !dn_q));

  // R4
  both_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (up_q && dn_q && !fr_tick && !fv_tick) |=> (!up_q && !dn_q));

  // R5
  no_coincident_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!up_q && !dn_q && fr_tick && fv_tick) |=> (!up_q && !dn_q));

endmodule

// File: rtl/pfd_err_outputs.sv
`timescale 1ns/1ps
module pfd_err_outputs #(
  parameter bit PHI_ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic up_nx,
  input  logic dn_nx,
  output logic se_drive,
  output logic se_oe,
  output logic phi_r,
  output logic phi_v
);
  import pfd_pkg::*;

  localparam logic PHI_IDLE = PHI_ACTIVE_LOW;

  err_state_e st;
  logic drive_d, oe_d;

  always_comb begin
    st      = err_state_e'({dn_nx, up_nx});
    drive_d = 1'b0;
    oe_d    = 1'b0;
    case (st)
      ERR_PUMP_UP: begin oe_d = 1'b1; drive_d = 1'b1; end
      ERR_PUMP_DN: begin oe_d = 1'b1; drive_d = 1'b0; end
      default:     begin oe_d = 1'b0; drive_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      se_drive <= 1'b0;
      se_oe    <= 1'b0;
    end else begin
      se_drive <= drive_d;
      se_oe    <= oe_d;
    end
  end

  generate
    if (PHI_ACTIVE_LOW) begin : g_low
      always_ff @(posedge clk) begin
        if (rst) begin
          phi_r <= PHI_IDLE;
          phi_v <= PHI_IDLE;
        end else begin
          phi_r <= ~up_nx;
          phi_v <= ~dn_nx;
        end
      end
    end else begin : g_high
      always_ff @(posedge clk) begin
        if (rst) begin
          phi_r <= PHI_IDLE;
          phi_v <= PHI_IDLE;
        end else begin
          phi_r <= up_nx;
          phi_v <= dn_nx;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pfd_lock_mon.sv
`timescale 1ns/1ps
module pfd_lock_mon #(
  parameter int LOCK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fr_tick,
  input  logic err_active,
  output logic lock
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic err_d1, long_err;

  always_comb begin
    long_err = err_active & err_d1;
    cnt_nx   = cnt_q;
    if (long_err)
      cnt_nx = '0;
    else if (fr_tick && cnt_q != CNT_MAX)
      cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      err_d1 <= 1'b0;
      lock   <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      err_d1 <= err_active;
      lock   <= (cnt_nx == CNT_MAX);
    end
  end

  // R9
  long_err_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    (err_active && err_d1) |=> !lock);

endmodule

// File: rtl/pfd_lock_detector.sv
`timescale 1ns/1ps
module pfd_lock_detector #(
  parameter int LOCK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fr_tick,
  input  logic fv_tick,
  output logic se_drive,
  output logic se_oe,
  output logic phi_r_n,
  output logic phi_v_n,
  output logic lock
);
  logic up_nx, dn_nx;

  pfd_state_core core_i (
    .clk     (clk),
    .rst     (rst),
    .fr_tick (fr_tick),
    .fv_tick (fv_tick),
    .up_nx   (up_nx),
    .dn_nx   (dn_nx)
  );

  pfd_err_outputs #(.PHI_ACTIVE_LOW(1'b1)) outs_i (
    .clk      (clk),
    .rst      (rst),
    .up_nx    (up_nx),
    .dn_nx    (dn_nx),
    .se_drive (se_drive),
    .se_oe    (se_oe),
    .phi_r    (phi_r_n),
    .phi_v    (phi_v_n)
  );

  pfd_lock_mon #(.LOCK_CYCLES(LOCK_CYCLES)) lock_i (
    .clk        (clk),
    .rst        (rst),
    .fr_tick    (fr_tick),
    .err_active (se_oe),
    .lock       (lock)
  );

  // R6
  oe_one_side_chk: assert property (@(posedge clk) disable iff (rst)
    se_oe |-> (phi_r_n != phi_v_n));

  // R6
  hiz_pair_equal_chk: assert property (@(posedge clk) disable iff (rst)
    !se_oe |-> (phi_r_n == phi_v_n));

  // R7
  drive_polarity_chk: assert property (@(posedge clk) disable iff (rst)
    se_oe |-> (se_drive == !phi_r_n));

endmodule

// File: tb/pfd_lock_detector_tb.sv
`timescale 1ns/1ps
module pfd_lock_detector_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fr_tick = 1'b0;
  logic fv_tick = 1'b0;
  logic se_drive, se_oe, phi_r_n, phi_v_n, lock;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pfd_lock_detector #(.LOCK_CYCLES(4)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .fr_tick  (fr_tick),
    .fv_tick  (fv_tick),
    .se_drive (se_drive),
    .se_oe    (se_oe),
    .phi_r_n  (phi_r_n),
    .phi_v_n  (phi_v_n),
    .lock     (lock)
  );

  // Packed view: {se_oe, se_drive, phi_r_n, phi_v_n}
  function automatic logic [3:0] err_view();
    return {se_oe, se_drive, phi_r_n, phi_v_n};
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Apply strobes for one cycle; return just after the capturing edge
  task automatic step(input logic fr, input logic fv);
    @(negedge clk);
    fr_tick = fr;
    fv_tick = fv;
    @(posedge clk);
    #1;
    fr_tick = 1'b0;
    fv_tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic test_reset();
    do_reset();
    chk("R1 error outputs", err_view(), 4'b0011);
    chk("R1 lock", {3'b0, lock}, 4'b0000);
  endtask

  task automatic test_ref_lead();
    step(1, 0);
    chk("R2 ref lead", err_view(), 4'b1101);
    step(0, 0);
    chk("R2 ref lead held", err_view(), 4'b1101);
    step(0, 1);
    chk("R4 both armed", err_view(), 4'b0000);
    step(0, 0);
    chk("R4 both cleared", err_view(), 4'b0011);
  endtask

  task automatic test_fb_lead();
    step(0, 1);
    chk("R3 fb lead", err_view(), 4'b1010);
    step(1, 0);
    chk("R4 both armed after fb", err_view(), 4'b0000);
    step(0, 0);
    chk("R4 cleared after fb", err_view(), 4'b0011);
  endtask

  task automatic test_coincident();
    step(1, 1);
    chk("R5 coincident from idle", err_view(), 4'b0011);
    step(1, 0);
    step(1, 1);
    chk("R5 coincident while pending", err_view(), 4'b1101);
    step(0, 1);
    step(0, 0);
    chk("R5 recovered", err_view(), 4'b0011);
  endtask

  task automatic test_clear_capture();
    step(1, 0);
    step(0, 1);
    chk("R10 armed", err_view(), 4'b0000);
    step(1, 0);
    chk("R10 strobe in clear cycle kept", err_view(), 4'b1101);
    step(0, 1);
    step(0, 0);
    chk("R10 back to idle", err_view(), 4'b0011);
  endtask

  task automatic aligned_period();
    step(1, 1);
    step(0, 0);
    step(0, 0);
  endtask

  task automatic test_lock_acquire(input string tag);
    for (int i = 0; i < 3; i++) aligned_period();
    chk({tag, " no lock after 3"}, {3'b0, lock}, 4'b0000);
    step(1, 1);
    chk({tag, " lock after 4th"}, {3'b0, lock}, 4'b0001);
  endtask

  task automatic test_short_pulse();
    step(1, 0);
    step(0, 1);
    step(0, 0);
    chk("R11 lock kept (ref lead)", {3'b0, lock}, 4'b0001);
    step(0, 1);
    step(1, 0);
    step(0, 0);
    chk("R11 lock kept (fb lead)", {3'b0, lock}, 4'b0001);
  endtask

  task automatic test_long_error();
    step(1, 0);
    step(0, 0);
    step(0, 0);
    chk("R9 lock dropped", {3'b0, lock}, 4'b0000);
    chk("R2 still pumping up", err_view(), 4'b1101);
    step(0, 1);
    step(0, 0);
    chk("R9 lock stays low", {3'b0, lock}, 4'b0000);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_ref_lead();
    test_fb_lead();
    test_coincident();
    test_clear_capture();
    do_reset();
    test_lock_acquire("R8");
    test_short_pulse();
    test_long_error();
    test_lock_acquire("R8 relock");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule